// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block produces a divided tick for a group of three timers. It counts events from one of four sources: half the internal clock, or rising edges on one of three external timer pins. When a programmed number of events has passed, it emits a tick that is one internal clock wide. The division ratio is the programmed reload value plus one.

Software writes the reload value and the source code in one write. The live down-counter can be read back at any time, but it cannot be written. The prescaler runs whenever at least one of the three timers is enabled. It stops, and holds its count, only when all three timer enables are low. When it becomes enabled again, it reloads from the programmed value.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset, `count_rd`, `preload_rd` and `pre_tick` are all zero, and the source code is 00.
- R2: A cycle with `cfg_wr` high stores `cfg_preload` and `cfg_src`. From the next cycle, `preload_rd[20:0]` shows the stored reload value.
- R3: The prescaler is enabled when any bit of `tmr_en` is set. While all bits are clear, `count_rd` holds its value and `pre_tick` stays low.
- R4: In the clock after the enable goes from clear to set, `count_rd` equals the stored reload value.
- R5: While enabled, each source event lowers the count by one. An event that finds the count at 0 reloads the stored value and raises `pre_tick` for one cycle. A reload value N therefore gives one tick per N+1 events.
- R6: Source code 00 creates an event on every second internal clock while the prescaler is enabled. With reload value N, ticks are 2(N+1) clocks apart.
- R7: Source codes 01, 10 and 11 select external pins 0, 1 and 2. Each pin passes through a two-stage synchronizer. Only low-to-high transitions count, and each one takes effect at the clock edge two cycles after the edge that first samples the high level. Falling edges and unselected pins have no effect.
- R8: `count_rd[20:0]` holds the live count, and `count_rd[23:21]` and `preload_rd[23:21]` always read 0.
- R9: `pre_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for reload value and source code |
| cfg_preload | input | 21 | Reload value to store |
| cfg_src | input | 2 | Source code: 00 half clock, 01/10/11 pin 0/1/2 |
| tmr_en | input | 3 | Enable bits of the three timers |
| ext_pin | input | 3 | External timer pins, asynchronous |
| count_rd | output | 24 | Live counter value, upper bits zero |
| preload_rd | output | 24 | Stored reload value, upper bits zero |
| pre_tick | output | 1 | One-cycle prescaler tick |

## Verification
The single-cycle tick and edge-pulse checks assume that an external pin stays below a quarter of the internal clock rate, so that two counted events never fall in adjacent cycles. The stimulus therefore holds each selected pin level for at least four clocks. The source code and reload value are changed only while all three timer enables are clear, because a switch while running is not guaranteed to be glitch-free. Unselected pins are toggled at other rates so that it is visible whether they leak into the count.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int CNT_W = 21;
    localparam int REG_W = 24;
    localparam int N_PIN = 3;
    localparam int SRC_W = $clog2(N_PIN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
        logic             tick;
    } cnt_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] preload;
        logic [SRC_W-1:0] src;
    } cfg_state_t;
endpackage

// File: rtl/tp_pin_edge.sv
module tp_pin_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [2:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[1:0], pin_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise_o[g] = sh_q[1] & ~sh_q[2];

        // R7
        rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end
endmodule

// File: rtl/tp_src_sel.sv
module tp_src_sel
    import tp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [N_PIN-1:0] rise_i,
    output logic             evt_o
);
    logic half_d, half_q;
    logic [N_PIN:0] cand;

    always_comb begin
        half_d = en_i ? ~half_q : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
    end

    assign cand  = {rise_i, half_q};
    assign evt_o = cand[src_i];

    // R6
    half_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && half_q) |=> !half_q);
endmodule

// File: rtl/tp_down_cnt.sv
module tp_down_cnt
    import tp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.tick    = 1'b0;
        st_d.en_prev = en_i;
        if (en_i && !st_q.en_prev) begin
            st_d.cnt = preload_i;
        end else if (en_i && evt_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt  = preload_i;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign tick_o  = st_q.tick;

    // R4
    load_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !st_q.en_prev) |=> (st_q.cnt == $past(preload_i)));
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == $past(st_q.cnt)) && !st_q.tick);
    // R5
    tick_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> ($past(st_q.cnt) == '0) && $past(evt_i));
    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_preload,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [N_PIN-1:0] tmr_en,
    input  logic [N_PIN-1:0] ext_pin,
    output logic [REG_W-1:0] count_rd,
    output logic [REG_W-1:0] preload_rd,
    output logic             pre_tick
);
    localparam int PAD_W = REG_W - CNT_W;

    cfg_state_t       cfg_d, cfg_q;
    logic             en;
    logic [N_PIN-1:0] rise;
    logic             evt;
    logic [CNT_W-1:0] count;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.preload = cfg_preload;
            cfg_d.src     = cfg_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en = |tmr_en;

    tp_pin_edge #(.N(N_PIN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (rise)
    );

    tp_src_sel u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .src_i  (cfg_q.src),
        .rise_i (rise),
        .evt_o  (evt)
    );

    tp_down_cnt u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .evt_i     (evt),
        .preload_i (cfg_q.preload),
        .count_o   (count),
        .tick_o    (pre_tick)
    );

    assign count_rd   = {{PAD_W{1'b0}}, count};
    assign preload_rd = {{PAD_W{1'b0}}, cfg_q.preload};

    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (preload_rd[CNT_W-1:0] == $past(cfg_preload)));
endmodule

// File: tb/tmr_prescaler_tb.sv
`timescale 1ns/1ps
module tmr_prescaler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [20:0] cfg_preload = '0;
    logic [1:0]  cfg_src = '0;
    logic [2:0]  tmr_en = '0;
    logic [2:0]  ext_pin = '0;
    logic [23:0] count_rd, preload_rd;
    logic        pre_tick;

    int nvec = 0, nfail = 0, cyc = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_pre = 0, m_src = 0;
    bit m_tick = 0, m_en_prev = 0, m_half = 0;
    bit p1[3], p2[3], p3[3];

    // interval tracking
    int last_tick = -1, exp_int = 0;
    string int_tag = "R6";
    bit prev_tick = 0;

    always #2.5 clk = ~clk;

    tmr_prescaler u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_preload(cfg_preload),
        .cfg_src(cfg_src), .tmr_en(tmr_en), .ext_pin(ext_pin),
        .count_rd(count_rd), .preload_rd(preload_rd), .pre_tick(pre_tick)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_src = 0; m_tick = 0; m_en_prev = 0; m_half = 0;
            for (int i = 0; i < 3; i++) begin p1[i] = 0; p2[i] = 0; p3[i] = 0; end
        end else begin
            bit en, ev;
            en = |tmr_en;
            ev = (m_src == 0) ? m_half : (p2[m_src-1] && !p3[m_src-1]);
            m_tick = 0;
            if (en && !m_en_prev) m_cnt = m_pre;
            else if (en && ev) begin
                if (m_cnt == 0) begin m_tick = 1; m_cnt = m_pre; end
                else m_cnt = m_cnt - 1;
            end
            m_half = en ? !m_half : 1'b0;
            m_en_prev = en;
            for (int i = 0; i < 3; i++) begin p3[i] = p2[i]; p2[i] = p1[i]; p1[i] = ext_pin[i]; end
            if (cfg_wr) begin m_pre = cfg_preload; m_src = cfg_src; end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check(count_rd[20:0] == m_cnt, "R5 count", count_rd[20:0], m_cnt);
            check(pre_tick == m_tick, "R5 tick", pre_tick, m_tick);
            check(preload_rd[20:0] == m_pre, "R2 preload", preload_rd[20:0], m_pre);
            check(count_rd[23:21] == 0 && preload_rd[23:21] == 0, "R8 upper",
                  {count_rd[23:21], preload_rd[23:21]}, 0);
            if (prev_tick) check(!pre_tick, "R9 width", pre_tick, 0);
            if (pre_tick) begin
                if (last_tick >= 0 && exp_int > 0)
                    check(cyc - last_tick == exp_int, int_tag, cyc - last_tick, exp_int);
                last_tick = cyc;
            end
            prev_tick = pre_tick;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input int pre, input int src);
        @(negedge clk);
        cfg_wr = 1; cfg_preload = pre[20:0]; cfg_src = src[1:0];
        @(negedge clk);
        cfg_wr = 0;
        check(preload_rd[20:0] == pre, "R2 readback", preload_rd[20:0], pre);
    endtask

    task automatic start_phase(input logic [2:0] en, input int interval, input string tag);
        last_tick = -1; exp_int = interval; int_tag = tag;
        tmr_en = en;
        @(negedge clk);
        check(count_rd[20:0] == cfg_preload, "R4 load", count_rd[20:0], cfg_preload);
    endtask

    task automatic stop_phase();
        int held;
        exp_int = 0;
        tmr_en = 0;
        @(negedge clk);
        held = count_rd[20:0];
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ext_pin = ~ext_pin;
            check(count_rd[20:0] == held && !pre_tick, "R3 hold", count_rd[20:0], held);
        end
        ext_pin = 0;
        wait_n(4);
    endtask

    task automatic run_ext(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % 4 == 3) ext_pin[sel] = ~ext_pin[sel];
            if (i % 3 == 2) ext_pin[(sel + 1) % 3] = ~ext_pin[(sel + 1) % 3];
            if (i % 5 == 4) ext_pin[(sel + 2) % 3] = ~ext_pin[(sel + 2) % 3];
        end
    endtask

    initial begin
        wait_n(3);
        rst_n = 1;
        @(negedge clk);
        check(count_rd == 0 && preload_rd == 0 && !pre_tick, "R1 reset",
              count_rd, 0);

        // R6: half-clock source, several reload values
        write_cfg(3, 0);
        start_phase(3'b010, 8, "R6 interval");
        wait_n(60);
        stop_phase();
        write_cfg(0, 0);
        start_phase(3'b100, 2, "R6 interval");
        wait_n(20);
        stop_phase();
        write_cfg(6, 0);
        start_phase(3'b001, 14, "R6 interval");
        wait_n(70);
        stop_phase();

        // R7: each external pin, selected pin period 8 clocks
        for (int s = 1; s <= 3; s++) begin
            write_cfg(2, s);
            start_phase(3'b011, 24, "R7 interval");
            run_ext(s - 1, 120);
            stop_phase();
            write_cfg(0, s);
            start_phase(3'b110, 8, "R7 interval");
            run_ext(s - 1, 60);
            stop_phase();
        end

        // R4 / R8: largest reload value
        write_cfg(21'h1FFFFF, 0);
        start_phase(3'b111, 0, "R6 interval");
        wait_n(20);
        check(count_rd[23:21] == 0, "R8 max", count_rd[23:21], 0);
        stop_phase();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule